// File: doc/BRIEF.md
# Cluster Performance Counter Unit

This block counts activity in a cache cluster. It has a set of 32-bit event counters and one 64-bit cycle counter. Software reaches every register through an indirect pair of ports. A write on the select port latches a 12-bit register index, and the data port then writes or reads the register at that index. The read port always shows the register named by the latched index. Cache activity arrives as single-cycle strobes on lanes. The lanes are grouped by event group and event code.

Each event counter names a group in its type register. A shared 64-bit event-selection register holds one 8-bit code per group and a master enable. A counter advances on the lane that belongs to its group and to that group's code. Three state vectors control the counters: counter enables, interrupt enables and overflow flags. Each vector has a set index and a clear index. In every vector the event counters keep their own bit positions, and the cycle counter always sits at bit 31. A level interrupt stays high while any flagged overflow has its interrupt enabled.

Top module: `cpmu_top`

## Requirements
- R1: A pulse on `selWr` latches `selIdx`. A `dataWr` pulse writes `dataIn` to the register at the index latched before that edge, even when `selWr` is high in the same cycle. `rdData` always shows the register at the latched index, and the value appears in the cycle after the select edge.
- R2: The fixed register indices are:
  - 0x400 control
  - 0x403 enable-clear and 0x404 enable-set
  - 0x405 interrupt-enable-clear and 0x406 interrupt-enable-set
  - 0x407 overflow-clear and 0x408 overflow-set
  - 0x409 cycle-counter control (32 bits, stored)
  - 0x40A cycle counter
  - 0x410 event selection (64 bits)
- R3: Event counter i has four registers at 0x420 + 0x10·i plus an offset. Offset 0 is count control (32 bits, stored). Offset 1 is the counter value. Offset 3 is the filter (32 bits, stored). Offset 4 is the type, a 3-bit group number in bits [2:0].
- R4: Control reads back the global enable in bit 0 and NUM_CTRS−1 in bits [15:11]. All its other bits read zero.
- R5: A control write loads the global enable from bit 0. Bit 1 clears all event counters and bit 2 clears the cycle counter, so writing 0x6 clears every counter and stops counting.
- R6: In the three mask vectors, event counter i uses bit i and the cycle counter uses bit 31. Bits of counters that do not exist always read zero, and writes to them are dropped.
- R7: A write to a set index ORs the written bits into the vector. A write to a clear index clears them. Both indices read back the current vector.
- R8: An event counter adds one per cycle when all of these hold:
  - global enable is set
  - its own enable bit is set
  - event selection bit 63 is set
  - the code c in bits [8g+7:8g] is below CODES, where g is the group in its type register
  - lane g·CODES+c is high

  A code of CODES or more counts nothing.
- R9: The cycle counter (64 bits) adds one on every clock while the global enable and enable bit 31 are both set.
- R10: Counters are loadable. A software write wins over an increment in the same cycle. An increment from all ones wraps to zero and sets the counter's overflow bit, and this wins over an overflow clear in the same cycle.
- R11: `irq` is high exactly when some counter has both its overflow bit and its interrupt-enable bit set. It stays high until one of the two is cleared.
- R12: A write to any index not listed in R2 or R3 changes nothing, and a read of such an index returns zero. This includes the registers of counters beyond NUM_CTRS−1.
- R13: After reset all registers, vectors and counters are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selWr | input | 1 | Latch `selIdx` as the register index |
| selIdx | input | 12 | Register index |
| dataWr | input | 1 | Write `dataIn` to the latched register |
| dataIn | input | 64 | Write data |
| evtLane | input | GROUPS·CODES | Event strobes, lane g·CODES+c |
| rdData | output | 64 | Contents of the latched register |
| irq | output | 1 | Overflow interrupt, level |

## Verification
Counting is first driven on the selected lane alone. Then strobes go to a wrong code in the same group. Then strobes go to the lane that an unguarded out-of-range code would alias onto. Together these separate correct lane selection from off-by-group and aliasing faults. The same strobes are then repeated with the selection master enable off, to show that it gates counting. Counters loaded just below all ones show whether overflow sets bit i for event counters and bit 31 for the cycle counter. Toggling the interrupt enable and overflow bits in turn shows that `irq` follows their AND. A select and a data write issued in the same cycle tell apart which index is used.

// File: rtl/cpmu_pkg.sv
package cpmu_pkg;

  localparam int IDX_W   = 12;
  localparam int CYC_BIT = 31;

  localparam logic [IDX_W-1:0] IX_CTRL    = 12'h400;
  localparam logic [IDX_W-1:0] IX_EN_CLR  = 12'h403;
  localparam logic [IDX_W-1:0] IX_EN_SET  = 12'h404;
  localparam logic [IDX_W-1:0] IX_INT_CLR = 12'h405;
  localparam logic [IDX_W-1:0] IX_INT_SET = 12'h406;
  localparam logic [IDX_W-1:0] IX_OV_CLR  = 12'h407;
  localparam logic [IDX_W-1:0] IX_OV_SET  = 12'h408;
  localparam logic [IDX_W-1:0] IX_CYC_CTL = 12'h409;
  localparam logic [IDX_W-1:0] IX_CYC_CNT = 12'h40A;
  localparam logic [IDX_W-1:0] IX_EVSEL   = 12'h410;
  localparam logic [IDX_W-1:0] IX_PER_CTR = 12'h420;

  typedef enum logic [3:0] {
    REG_NONE, REG_CTRL, REG_EN_CLR, REG_EN_SET, REG_INT_CLR, REG_INT_SET,
    REG_OV_CLR, REG_OV_SET, REG_CYC_CTL, REG_CYC_CNT, REG_EVSEL,
    REG_CNT_CTL, REG_CNT_VAL, REG_FILT, REG_TYPE
  } regKind_e;

  // strobes from the access control to the datapath
  typedef struct packed {
    regKind_e    kind;
    logic [3:0]  ctr;
    logic        wr;
  } regAccess_t;

endpackage

// File: rtl/cpmu_ctrl.sv
module cpmu_ctrl
  import cpmu_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selWr,
  input  logic [IDX_W-1:0] selIdx,
  input  logic             dataWr,
  output regAccess_t       acc
);

  logic [IDX_W-1:0] selQ;
  logic [IDX_W-1:0] perOff;
  regKind_e         kind;
  logic [3:0]       ctrNum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      selQ <= '0;
    else if (selWr) selQ <= selIdx;
  end

  assign perOff = selQ - IX_PER_CTR;

  always_comb begin
    kind   = REG_NONE;
    ctrNum = perOff[7:4];
    unique case (selQ)
      IX_CTRL:    kind = REG_CTRL;
      IX_EN_CLR:  kind = REG_EN_CLR;
      IX_EN_SET:  kind = REG_EN_SET;
      IX_INT_CLR: kind = REG_INT_CLR;
      IX_INT_SET: kind = REG_INT_SET;
      IX_OV_CLR:  kind = REG_OV_CLR;
      IX_OV_SET:  kind = REG_OV_SET;
      IX_CYC_CTL: kind = REG_CYC_CTL;
      IX_CYC_CNT: kind = REG_CYC_CNT;
      IX_EVSEL:   kind = REG_EVSEL;
      default: begin
        if (selQ >= IX_PER_CTR && perOff[IDX_W-1:8] == '0 &&
            int'(ctrNum) < NUM_EVT) begin
          case (perOff[3:0])
            4'h0:    kind = REG_CNT_CTL;
            4'h1:    kind = REG_CNT_VAL;
            4'h3:    kind = REG_FILT;
            4'h4:    kind = REG_TYPE;
            default: kind = REG_NONE;
          endcase
        end
      end
    endcase
  end

  assign acc.kind = kind;
  assign acc.ctr  = ctrNum;
  assign acc.wr   = dataWr && (kind != REG_NONE);

endmodule

// File: rtl/cpmu_datapath.sv
module cpmu_datapath
  import cpmu_pkg::*;
#(
  parameter int NUM_CTRS = 5,
  parameter int GROUPS   = 8,
  parameter int CODES    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  regAccess_t               acc,
  input  logic [63:0]              wrData,
  input  logic [GROUPS*CODES-1:0]  evtLane,
  output logic [63:0]              rdData,
  output logic                     irq
);

  localparam int NUM_EVT = NUM_CTRS - 1;
  localparam int LANES   = GROUPS * CODES;
  localparam int LW      = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int GW      = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam logic [31:0] PRESENT =
    (32'd1 << CYC_BIT) | 32'((64'd1 << NUM_EVT) - 64'd1);

  logic        globalEn;
  logic [31:0] cntEn, intEn, ovf, cycCtl;
  logic [63:0] cycCnt, evSel;
  logic [NUM_EVT-1:0][31:0]   cntVec, ctlVec, filtVec;
  logic [NUM_EVT-1:0][GW-1:0] typeVec;
  logic [NUM_EVT-1:0]         evWrap;
  logic [31:0] maskWr, ovfEvt;
  logic        clrEvt, clrCyc, cycHit, cycWr, cycWrap;

  function automatic logic isWr(regAccess_t a, regKind_e k);
    return a.wr && a.kind == k;
  endfunction

  assign maskWr = wrData[31:0] & PRESENT;
  assign clrEvt = isWr(acc, REG_CTRL) && wrData[1];
  assign clrCyc = isWr(acc, REG_CTRL) && wrData[2];

  // global control and the three mask vectors
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      cntEn    <= '0;
      intEn    <= '0;
      ovf      <= '0;
      cycCtl   <= '0;
      evSel    <= '0;
    end else begin
      if (isWr(acc, REG_CTRL))    globalEn <= wrData[0];
      if (isWr(acc, REG_EN_SET))  cntEn <= cntEn | maskWr;
      if (isWr(acc, REG_EN_CLR))  cntEn <= cntEn & ~maskWr;
      if (isWr(acc, REG_INT_SET)) intEn <= intEn | maskWr;
      if (isWr(acc, REG_INT_CLR)) intEn <= intEn & ~maskWr;
      if (isWr(acc, REG_CYC_CTL)) cycCtl <= wrData[31:0];
      if (isWr(acc, REG_EVSEL))   evSel <= wrData;
      ovf <= ((ovf | (isWr(acc, REG_OV_SET) ? maskWr : 32'd0))
                   & ~(isWr(acc, REG_OV_CLR) ? maskWr : 32'd0)) | ovfEvt;
    end
  end

  // cycle counter
  assign cycHit  = globalEn && cntEn[CYC_BIT];
  assign cycWr   = isWr(acc, REG_CYC_CNT);
  assign cycWrap = cycHit && !cycWr && !clrCyc && (&cycCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cycCnt <= '0;
    else if (clrCyc) cycCnt <= '0;
    else if (cycWr)  cycCnt <= wrData;
    else if (cycHit) cycCnt <= cycCnt + 64'd1;
  end

  // event counters
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_ctr
    logic [GW-1:0] grp;
    logic [7:0]    code;
    logic [LW-1:0] laneIdx;
    logic          codeOk, hit, wrVal;
    logic [31:0]   cnt, ctl, filt;
    logic [GW-1:0] typ;

    assign grp     = typ;
    assign code    = evSel[8*grp +: 8];
    assign codeOk  = int'(code) < CODES;
    assign laneIdx = LW'(int'(grp) * CODES + int'(code));
    assign hit     = globalEn && cntEn[i] && evSel[63] && codeOk &&
                     evtLane[laneIdx];
    assign wrVal   = isWr(acc, REG_CNT_VAL) && acc.ctr == 4'(i);
    assign evWrap[i] = hit && !wrVal && !clrEvt && (&cnt);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       cnt <= '0;
      else if (clrEvt) cnt <= '0;
      else if (wrVal)  cnt <= wrData[31:0];
      else if (hit)    cnt <= cnt + 32'd1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctl  <= '0;
        filt <= '0;
        typ  <= '0;
      end else if (acc.wr && acc.ctr == 4'(i)) begin
        if (acc.kind == REG_CNT_CTL) ctl  <= wrData[31:0];
        if (acc.kind == REG_FILT)    filt <= wrData[31:0];
        if (acc.kind == REG_TYPE)    typ  <= wrData[GW-1:0];
      end
    end

    assign cntVec[i]  = cnt;
    assign ctlVec[i]  = ctl;
    assign filtVec[i] = filt;
    assign typeVec[i] = typ;
  end

  assign ovfEvt = 32'(evWrap) | (32'(cycWrap) << CYC_BIT);
  assign irq    = |(ovf & intEn);

  // read mux
  always_comb begin
    rdData = '0;
    case (acc.kind)
      REG_CTRL: begin
        rdData[15:11] = 5'(NUM_CTRS - 1);
        rdData[0]     = globalEn;
      end
      REG_EN_CLR,  REG_EN_SET:  rdData[31:0] = cntEn;
      REG_INT_CLR, REG_INT_SET: rdData[31:0] = intEn;
      REG_OV_CLR,  REG_OV_SET:  rdData[31:0] = ovf;
      REG_CYC_CTL:              rdData[31:0] = cycCtl;
      REG_CYC_CNT:              rdData       = cycCnt;
      REG_EVSEL:                rdData       = evSel;
      REG_CNT_CTL, REG_CNT_VAL, REG_FILT, REG_TYPE: begin
        for (int k = 0; k < NUM_EVT; k++) begin
          if (acc.ctr == 4'(k)) begin
            case (acc.kind)
              REG_CNT_CTL: rdData[31:0] = ctlVec[k];
              REG_CNT_VAL: rdData[31:0] = cntVec[k];
              REG_FILT:    rdData[31:0] = filtVec[k];
              default:     rdData[GW-1:0] = typeVec[k];
            endcase
          end
        end
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/cpmu_top.sv
module cpmu_top
  import cpmu_pkg::*;
#(
  parameter int NUM_CTRS = 5,
  parameter int GROUPS   = 8,
  parameter int CODES    = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    selWr,
  input  logic [11:0]             selIdx,
  input  logic                    dataWr,
  input  logic [63:0]             dataIn,
  input  logic [GROUPS*CODES-1:0] evtLane,
  output logic [63:0]             rdData,
  output logic                    irq
);

  regAccess_t acc;

  cpmu_ctrl #(.NUM_EVT(NUM_CTRS - 1)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .selWr  (selWr),
    .selIdx (selIdx),
    .dataWr (dataWr),
    .acc    (acc)
  );

  cpmu_datapath #(
    .NUM_CTRS (NUM_CTRS),
    .GROUPS   (GROUPS),
    .CODES    (CODES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .acc     (acc),
    .wrData  (dataIn),
    .evtLane (evtLane),
    .rdData  (rdData),
    .irq     (irq)
  );

endmodule

// File: rtl/cpmu_checker.sv
module cpmu_checker #(
  parameter int NUM_CTRS = 5
) (
  input logic        clk,
  input logic        rstN,
  input logic        selWr,
  input logic [11:0] selIdx,
  input logic        dataWr,
  input logic [63:0] dataIn,
  input logic [63:0] rdData,
  input logic        irq
);

  localparam logic [31:0] PRES =
    (32'd1 << 31) | 32'((64'd1 << (NUM_CTRS - 1)) - 64'd1);

  logic [11:0] idxQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      idxQ <= '0;
    else if (selWr) idxQ <= selIdx;
  end

  a_r4_count_field: assert property (@(posedge clk) disable iff (!rstN)
    (idxQ == 12'h400) |-> (rdData[15:11] == 5'(NUM_CTRS - 1)));

  a_r12_unimpl_zero: assert property (@(posedge clk) disable iff (!rstN)
    (idxQ < 12'h400) |-> (rdData == 64'd0));

  a_r6_absent_bits: assert property (@(posedge clk) disable iff (!rstN)
    (idxQ == 12'h404) |-> ((rdData[31:0] & ~PRES) == 32'd0 && rdData[63:32] == 32'd0));

  a_r7_set_or: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !selWr && idxQ == 12'h404) |=>
      ((rdData[31:0] & $past(dataIn[31:0]) & PRES) == ($past(dataIn[31:0]) & PRES)));

  a_r7_clr: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !selWr && idxQ == 12'h403) |=>
      ((rdData[31:0] & $past(dataIn[31:0]) & PRES) == 32'd0));

  a_r11_irq_off: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && idxQ == 12'h405 && (dataIn[31:0] & PRES) == PRES) |=> !irq);

  a_r9_cyc_step: assert property (@(posedge clk) disable iff (!rstN)
    (idxQ == 12'h40A && $past(idxQ) == 12'h40A && !$past(dataWr)) |->
      (rdData == $past(rdData) || rdData == $past(rdData) + 64'd1));

endmodule

bind cpmu_top cpmu_checker #(.NUM_CTRS(NUM_CTRS)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .selWr  (selWr),
  .selIdx (selIdx),
  .dataWr (dataWr),
  .dataIn (dataIn),
  .rdData (rdData),
  .irq    (irq)
);

// File: tb/tb_cpmu_top.sv
module tb_cpmu_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCTR  = 5;
  localparam int NE    = NCTR - 1;
  localparam int GRP   = 8;
  localparam int CODES = 4;
  localparam logic [31:0] PRES = 32'h8000_000F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selWr = 1'b0;
  logic [11:0] selIdx = '0;
  logic        dataWr = 1'b0;
  logic [63:0] dataIn = '0;
  logic [GRP*CODES-1:0] evtLane = '0;
  logic [63:0] rdData;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  cpmu_top #(.NUM_CTRS(NCTR), .GROUPS(GRP), .CODES(CODES)) dut (
    .clk(clk), .rstN(rstN), .selWr(selWr), .selIdx(selIdx),
    .dataWr(dataWr), .dataIn(dataIn), .evtLane(evtLane),
    .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit        mEn;
  bit [31:0] mCe, mIe, mOv, mCycCtl;
  bit [63:0] mCyc, mEs;
  int        mSel;
  bit [31:0] mCnt [NE];
  bit [31:0] mCc  [NE];
  bit [31:0] mFl  [NE];
  bit [2:0]  mTy  [NE];

  function automatic bit [63:0] mRead(int idx);
    int k, s;
    case (idx)
      'h400: return 64'(mEn) | (64'(NCTR - 1) << 11);
      'h403, 'h404: return 64'(mCe);
      'h405, 'h406: return 64'(mIe);
      'h407, 'h408: return 64'(mOv);
      'h409: return 64'(mCycCtl);
      'h40A: return mCyc;
      'h410: return mEs;
      default: begin
        if (idx >= 'h420 && idx < 'h420 + 16*NE) begin
          k = (idx - 'h420) / 16;
          s = (idx - 'h420) % 16;
          case (s)
            0: return 64'(mCc[k]);
            1: return 64'(mCnt[k]);
            3: return 64'(mFl[k]);
            4: return 64'(mTy[k]);
            default: return 64'd0;
          endcase
        end
        return 64'd0;
      end
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit [31:0] nCnt [NE];
    bit [31:0] wraps, setOv, clrOv, mw;
    bit [63:0] nCyc;
    bit [7:0]  c;
    int g, k, s;
    if (!rstN) begin
      mEn = 0; mCe = 0; mIe = 0; mOv = 0; mCycCtl = 0; mCyc = 0; mEs = 0; mSel = 0;
      for (int i = 0; i < NE; i++) begin
        mCnt[i] = 0; mCc[i] = 0; mFl[i] = 0; mTy[i] = 0;
      end
    end else begin
      wraps = 0; setOv = 0; clrOv = 0;
      mw = dataIn[31:0] & PRES;
      for (int i = 0; i < NE; i++) begin
        g = int'(mTy[i]);
        c = mEs[8*g +: 8];
        nCnt[i] = mCnt[i];
        if (mEn && mCe[i] && mEs[63] && int'(c) < CODES && evtLane[g*CODES + int'(c)]) begin
          nCnt[i] = mCnt[i] + 1;
          if (mCnt[i] == 32'hFFFF_FFFF) wraps[i] = 1;
        end
      end
      nCyc = mCyc;
      if (mEn && mCe[31]) begin
        nCyc = mCyc + 1;
        if (mCyc == '1) wraps[31] = 1;
      end
      if (dataWr) begin
        case (mSel)
          'h400: begin
            mEn = dataIn[0];
            if (dataIn[1]) for (int i = 0; i < NE; i++) begin nCnt[i] = 0; wraps[i] = 0; end
            if (dataIn[2]) begin nCyc = 0; wraps[31] = 0; end
          end
          'h403: mCe = mCe & ~mw;
          'h404: mCe = mCe | mw;
          'h405: mIe = mIe & ~mw;
          'h406: mIe = mIe | mw;
          'h407: clrOv = mw;
          'h408: setOv = mw;
          'h409: mCycCtl = dataIn[31:0];
          'h40A: begin nCyc = dataIn; wraps[31] = 0; end
          'h410: mEs = dataIn;
          default: begin
            if (mSel >= 'h420 && mSel < 'h420 + 16*NE) begin
              k = (mSel - 'h420) / 16;
              s = (mSel - 'h420) % 16;
              case (s)
                0: mCc[k] = dataIn[31:0];
                1: begin nCnt[k] = dataIn[31:0]; wraps[k] = 0; end
                3: mFl[k] = dataIn[31:0];
                4: mTy[k] = dataIn[2:0];
                default: ;
              endcase
            end
          end
        endcase
      end
      for (int i = 0; i < NE; i++) mCnt[i] = nCnt[i];
      mCyc = nCyc;
      mOv  = ((mOv | setOv) & ~clrOv) | wraps;
      if (selWr) mSel = int'(selIdx);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (rdData !== mRead(mSel)) begin
        fails++;
        $display("FAIL R1 model compare idx=%h actual=%h expected=%h", mSel, rdData, mRead(mSel));
      end
      checks++;
      if (irq !== |(mOv & mIe)) begin
        fails++;
        $display("FAIL R11 model irq actual=%b expected=%b", irq, |(mOv & mIe));
      end
    end
  end

  task automatic expect64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [11:0] idx, logic [63:0] v);
    selWr = 1'b1; selIdx = idx;
    @(negedge clk);
    selWr = 1'b0; dataWr = 1'b1; dataIn = v;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic chkReg(string tag, logic [11:0] idx, logic [63:0] exp);
    selWr = 1'b1; selIdx = idx;
    @(negedge clk);
    selWr = 1'b0;
    expect64(tag, rdData, exp);
  endtask

  task automatic pulse(int lane, int n);
    for (int j = 0; j < n; j++) begin
      evtLane[lane] = 1'b1;
      @(negedge clk);
      evtLane = '0;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state, R4 count field
    expect64("R13 irq after reset", {63'd0, irq}, 64'd0);
    chkReg("R13 R4 control after reset", 12'h400, 64'h2000);
    chkReg("R13 enable vector after reset", 12'h404, 64'd0);
    chkReg("R13 counter after reset", 12'h421, 64'd0);

    // R6 R7 mask vectors
    wrReg(12'h404, 64'hFFFF_FFFF_FFFF_FFFF);
    chkReg("R6 enable set present only", 12'h404, 64'h8000_000F);
    chkReg("R7 clear index reads state", 12'h403, 64'h8000_000F);
    wrReg(12'h403, 64'h5);
    chkReg("R7 clear bits 0 and 2", 12'h404, 64'h8000_000A);
    wrReg(12'h404, 64'h5);

    // R12 unimplemented indices, R3 absent counter
    wrReg(12'h401, 64'h1234);
    chkReg("R12 unimplemented reads zero", 12'h401, 64'd0);
    wrReg(12'h460, 64'h77);
    chkReg("R12 R3 absent counter reads zero", 12'h460, 64'd0);
    chkReg("R12 no side effect", 12'h404, 64'h8000_000F);

    // R2 R3 stored registers
    wrReg(12'h409, 64'h1234);
    chkReg("R2 cycle control stored", 12'h409, 64'h1234);
    wrReg(12'h453, 64'hABCD);
    chkReg("R3 filter of counter 3", 12'h453, 64'hABCD);
    wrReg(12'h434, 64'h2);
    chkReg("R3 type of counter 1", 12'h434, 64'h2);

    // R8 counting on group 2 code 3 -> lane 11
    wrReg(12'h410, 64'h8000_0000_0003_0000);
    wrReg(12'h431, 64'd0);
    wrReg(12'h400, 64'h1);
    pulse(11, 3);
    pulse(10, 2);
    wrReg(12'h400, 64'h0);
    chkReg("R8 counter 1 counted selected lane", 12'h431, 64'd3);
    chkReg("R8 counter 0 idle", 12'h421, 64'd0);
    // selection master enable off
    wrReg(12'h410, 64'h0000_0000_0003_0000);
    wrReg(12'h400, 64'h1);
    pulse(11, 2);
    wrReg(12'h400, 64'h0);
    chkReg("R8 master enable gates", 12'h431, 64'd3);
    // code out of range: group 2 code 9 must not alias lane 17
    wrReg(12'h410, 64'h8000_0000_0009_0000);
    wrReg(12'h400, 64'h1);
    pulse(17, 2);
    wrReg(12'h400, 64'h0);
    chkReg("R8 out-of-range code counts nothing", 12'h431, 64'd3);

    // R10 R11 event overflow
    wrReg(12'h410, 64'h8000_0000_0003_0000);
    wrReg(12'h431, 64'hFFFF_FFFE);
    wrReg(12'h406, 64'h2);
    wrReg(12'h400, 64'h1);
    pulse(11, 2);
    wrReg(12'h400, 64'h0);
    chkReg("R10 overflow bit 1", 12'h408, 64'h2);
    chkReg("R10 counter wrapped", 12'h431, 64'd0);
    expect64("R11 irq raised", {63'd0, irq}, 64'd1);
    wrReg(12'h405, 64'h2);
    expect64("R11 irq masked", {63'd0, irq}, 64'd0);
    wrReg(12'h406, 64'h2);
    expect64("R11 irq unmasked", {63'd0, irq}, 64'd1);
    wrReg(12'h407, 64'hFFFF_FFFF);
    expect64("R11 irq after overflow clear", {63'd0, irq}, 64'd0);
    chkReg("R7 overflow cleared", 12'h408, 64'd0);

    // R9 R10 cycle counter
    wrReg(12'h40A, 64'hFFFF_FFFF_FFFF_FFFD);
    chkReg("R9 cycle counter holds when disabled", 12'h40A, 64'hFFFF_FFFF_FFFF_FFFD);
    wrReg(12'h400, 64'h1);
    repeat (6) @(negedge clk);
    wrReg(12'h400, 64'h0);
    chkReg("R9 R10 cycle overflow at bit 31", 12'h408, 64'h8000_0000);

    // R5 control reset
    wrReg(12'h431, 64'h55);
    wrReg(12'h400, 64'h6);
    chkReg("R5 event counters cleared", 12'h431, 64'd0);
    chkReg("R5 cycle counter cleared", 12'h40A, 64'd0);
    chkReg("R5 R4 control after reset write", 12'h400, 64'h2000);

    // R1 select and data in the same cycle use the old index
    selWr = 1'b1; selIdx = 12'h409;
    @(negedge clk);
    selIdx = 12'h423; dataWr = 1'b1; dataIn = 64'h55;
    @(negedge clk);
    selWr = 1'b0; dataWr = 1'b0;
    expect64("R1 read shows new index", rdData, 64'd0);
    chkReg("R1 write used old index", 12'h409, 64'h55);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule